// File: doc/BRIEF.md
# Cascadable Masked Signature Compressor

This block folds a stream of parallel data words into a W-bit signature (W is 16 by default). It is a multiple-input signature register built on linear-feedback shift-register feedback. On every qualified step the register shifts one place toward its most significant bit and takes in a new least significant bit. The incoming data word, with its masked bits forced to zero, is then XORed across the shifted value.

The word comes from one of two places. One is a live monitored bus, which advances on that bus's qualifier strobe. The other is a local capture memory, which advances on that memory's valid strobe. Two configuration registers shape the compression. A mask register removes any subset of input bits, and a tap register picks which signature bits are XORed into the feedback bit. Both can be changed at run time. A third register holds a seed that a synchronous load copies into the signature.

Several units can be chained into one wider register. A neighbour link carries each unit's top bit to the unit above it. A shared bidirectional cascade pin carries the feedback bit from the most significant unit back to the least significant one. A small register interface writes the configuration and reads back the configuration and the signature.

Top module: `csig_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it, the signature and the seed register read 0, the mask register reads 0, and the tap register reads 16'hD008.
- R2: On a step with no seed load, the next signature is {sig[W-2:0], lsb_in} XOR (data AND NOT mask). In solo role, lsb_in is the feedback bit.
- R3: When `comp_en` is low, or the selected source's strobe is low, the signature holds its value.
- R4: A data bit whose mask bit is 1 contributes zero. With an all-ones mask and a zero tap register, the signature never leaves 0.
- R5: The feedback bit is the XOR of the signature bits selected by the ones in the tap register.
- R6: With `src_sel`=0 a step uses `bus_data` and is triggered by `bus_qual`. With `src_sel`=1 a step uses `mem_data` and is triggered by `mem_valid`. The input pair that is not selected has no effect.
- R7: A `seed_load` pulse makes the signature equal to the seed register on the next cycle. It takes priority over a step in the same cycle.
- R8: A write through `cfg_we` is ignored while `comp_en` is high.
- R9: `cfg_rdata` shows the register picked by `cfg_addr` one cycle later: 0 for mask, 1 for taps, 2 for seed, 3 for signature. A read never changes the signature.
- R10: `role` is encoded as 0 solo, 1 head, 2 middle, 3 tail. In solo and head, `casc_io` is driven with the feedback bit. In middle and tail it is left at high impedance.
- R11: The least significant stage takes the feedback bit in solo role, `chain_in` in head and middle roles, and the value on `casc_io` in tail role. `chain_out` carries sig[W-1].
- R12: A head unit (upper half) and a tail unit (lower half) share `casc_io` and are linked through `chain_out` to `chain_in`. Stepped together, they act as one 2W-bit register whose feedback uses taps in the upper half only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| role | input | 2 | Cascade role: 0 solo, 1 head, 2 middle, 3 tail |
| comp_en | input | 1 | Enables compression; also locks configuration writes |
| src_sel | input | 1 | Input source: 0 live bus, 1 capture memory |
| bus_data | input | W | Live monitored bus word |
| bus_qual | input | 1 | Qualified sample strobe for the live bus |
| mem_data | input | W | Word read from the capture memory |
| mem_valid | input | 1 | Valid strobe for the memory word |
| seed_load | input | 1 | Copies the seed register into the signature |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select for write and readback |
| cfg_wdata | input | W | Configuration write data |
| cfg_rdata | output | W | Registered readback data |
| sig_out | output | W | Current signature |
| chain_in | input | 1 | Top bit of the unit below, in a chain |
| chain_out | output | 1 | This unit's top signature bit |
| casc_io | inout | 1 | Shared feedback line for a chain of units |

## Verification
The assertions assume three things. The role input does not change while compression is enabled. Exactly one unit in a chain is in solo or head role. All units of a chain see the same step strobes and seed loads in the same cycle. The bench changes the role only while `comp_en` is low. It gives the chained pair shared strobes and a single head. It drives the cascade line itself only while the unit under test is in middle or tail role, so the line never has two drivers.

// File: rtl/csig_pkg.sv
package csig_pkg;
  typedef enum logic [1:0] {
    ROLE_SOLO = 2'd0,
    ROLE_HEAD = 2'd1,
    ROLE_MID  = 2'd2,
    ROLE_TAIL = 2'd3
  } role_e;

  localparam logic [1:0] A_MASK = 2'd0;
  localparam logic [1:0] A_TAPS = 2'd1;
  localparam logic [1:0] A_SEED = 2'd2;
  localparam logic [1:0] A_SIG  = 2'd3;
endpackage

// File: rtl/csig_cfg.sv
module csig_cfg
  import csig_pkg::*;
#(
  parameter int W = 16,
  parameter logic [W-1:0] TAP_RST = 16'hD008
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         comp_en,
  input  logic         we,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] sig_in,
  output logic [W-1:0] mask,
  output logic [W-1:0] taps,
  output logic [W-1:0] seed,
  output logic [W-1:0] rdata
);
  logic wr_ok;
  assign wr_ok = we && !comp_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask  <= '0;
      taps  <= TAP_RST;
      seed  <= '0;
      rdata <= '0;
    end else begin
      if (wr_ok) begin
        case (addr)
          A_MASK:  mask <= wdata;
          A_TAPS:  taps <= wdata;
          A_SEED:  seed <= wdata;
          default: ;
        endcase
      end
      case (addr)
        A_MASK:  rdata <= mask;
        A_TAPS:  rdata <= taps;
        A_SEED:  rdata <= seed;
        default: rdata <= sig_in;
      endcase
    end
  end

  // R8: configuration is frozen while compression runs
  p_cfg_lock_r8: assert property (@(posedge clk) disable iff (rst)
    comp_en |=> ($stable(mask) && $stable(taps) && $stable(seed)));

  // R9: signature readback follows the signature with one cycle latency
  p_read_sig_r9: assert property (@(posedge clk) disable iff (rst)
    (addr == A_SIG) |=> (rdata == $past(sig_in)));
endmodule

// File: rtl/csig_src.sv
module csig_src #(
  parameter int W = 16
) (
  input  logic         comp_en,
  input  logic         src_sel,
  input  logic [W-1:0] bus_data,
  input  logic         bus_qual,
  input  logic [W-1:0] mem_data,
  input  logic         mem_valid,
  input  logic [W-1:0] mask,
  output logic         step,
  output logic [W-1:0] data_m
);
  logic [W-1:0] raw;
  logic         strobe;

  always_comb begin
    if (src_sel) begin
      raw    = mem_data;
      strobe = mem_valid;
    end else begin
      raw    = bus_data;
      strobe = bus_qual;
    end
    step = comp_en && strobe;
  end

  for (genvar i = 0; i < W; i++) begin : g_mask
    assign data_m[i] = raw[i] & ~mask[i];
  end
endmodule

// File: rtl/csig_core.sv
module csig_core
  import csig_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         seed_load,
  input  logic [W-1:0] seed,
  input  logic [W-1:0] data_m,
  input  logic [W-1:0] taps,
  input  logic [W-1:0] mask,
  input  role_e        role,
  input  logic         casc_in,
  input  logic         chain_in,
  output logic [W-1:0] sig,
  output logic         fb,
  output logic         drive_en,
  output logic         chain_out
);
  logic         lsb_in;
  logic [W-1:0] nxt;

  assign fb        = ^(sig & taps);
  assign drive_en  = (role == ROLE_SOLO) || (role == ROLE_HEAD);
  assign chain_out = sig[W-1];

  always_comb begin
    case (role)
      ROLE_SOLO: lsb_in = fb;
      ROLE_TAIL: lsb_in = casc_in;
      default:   lsb_in = chain_in;
    endcase
  end

  for (genvar i = 0; i < W; i++) begin : g_next
    if (i == 0) begin : g_lsb
      assign nxt[i] = lsb_in ^ data_m[i];
    end else begin : g_up
      assign nxt[i] = sig[i-1] ^ data_m[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            sig <= '0;
    else if (seed_load) sig <= seed;
    else if (step)      sig <= nxt;
  end

  // R3: no step and no load leaves the signature unchanged
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!step && !seed_load) |=> $stable(sig));

  // R7: a seed load wins over a step
  p_seed_r7: assert property (@(posedge clk) disable iff (rst)
    seed_load |=> (sig == $past(seed)));

  // R4: masked positions change only by the shift
  p_mask_r4: assert property (@(posedge clk) disable iff (rst)
    (step && !seed_load) |=>
      ((($past(sig) << 1) ^ sig) & $past(mask) & ~{{(W-1){1'b0}}, 1'b1}) == '0);

  // R2: upper stages take the lower neighbour XOR data
  p_shift_r2: assert property (@(posedge clk) disable iff (rst)
    (step && !seed_load) |=>
      ((sig[W-1:1] ^ $past(data_m[W-1:1])) == $past(sig[W-2:0])));
endmodule

// File: rtl/csig_top.sv
module csig_top
  import csig_pkg::*;
#(
  parameter int W = 16,
  parameter logic [W-1:0] TAP_RST = 16'hD008
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   role,
  input  logic         comp_en,
  input  logic         src_sel,
  input  logic [W-1:0] bus_data,
  input  logic         bus_qual,
  input  logic [W-1:0] mem_data,
  input  logic         mem_valid,
  input  logic         seed_load,
  input  logic         cfg_we,
  input  logic [1:0]   cfg_addr,
  input  logic [W-1:0] cfg_wdata,
  output logic [W-1:0] cfg_rdata,
  output logic [W-1:0] sig_out,
  input  logic         chain_in,
  output logic         chain_out,
  inout  wire          casc_io
);
  logic [W-1:0] mask, taps, seed, data_m, sig;
  logic         step, fb, drive_en;
  role_e        role_q;

  assign role_q  = role_e'(role);
  assign sig_out = sig;
  assign casc_io = drive_en ? fb : 1'bz;

  csig_cfg #(.W(W), .TAP_RST(TAP_RST)) u_cfg (
    .clk(clk), .rst(rst), .comp_en(comp_en), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .sig_in(sig), .mask(mask), .taps(taps), .seed(seed),
    .rdata(cfg_rdata)
  );

  csig_src #(.W(W)) u_src (
    .comp_en(comp_en), .src_sel(src_sel), .bus_data(bus_data),
    .bus_qual(bus_qual), .mem_data(mem_data), .mem_valid(mem_valid),
    .mask(mask), .step(step), .data_m(data_m)
  );

  csig_core #(.W(W)) u_core (
    .clk(clk), .rst(rst), .step(step), .seed_load(seed_load), .seed(seed),
    .data_m(data_m), .taps(taps), .mask(mask), .role(role_q),
    .casc_in(casc_io), .chain_in(chain_in), .sig(sig), .fb(fb),
    .drive_en(drive_en), .chain_out(chain_out)
  );

  // R10: followers never drive the shared line
  p_pin_release_r10: assert property (@(posedge clk) disable iff (rst)
    ((role == 2'd2) || (role == 2'd3)) |-> !drive_en);

  // R1: first cycle after reset shows the cleared signature
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (sig_out == '0));
endmodule

// File: tb/sim_csig_top.sv
`timescale 1ns/1ps
module sim_csig_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] role = 2'd0;
  logic comp_en = 0, src_sel = 0, bus_qual = 0, mem_valid = 0, seed_load = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_addr = 2'd0;
  logic [15:0] wd0 = 0, wdh = 0, wdl = 0;
  logic [15:0] bus0 = 0, mem0 = 0, bus_h = 0, bus_l = 0;
  logic chain0 = 0, tb_drv = 0, tb_val = 0;
  logic [15:0] rd0, sig0, rdh, rdl, sigh, sigl;
  logic co0, coh, col;
  wire casc0, casc_c;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;
  assign casc0 = tb_drv ? tb_val : 1'bz;

  csig_top u0 (
    .clk(clk), .rst(rst), .role(role), .comp_en(comp_en), .src_sel(src_sel),
    .bus_data(bus0), .bus_qual(bus_qual), .mem_data(mem0), .mem_valid(mem_valid),
    .seed_load(seed_load), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(wd0),
    .cfg_rdata(rd0), .sig_out(sig0), .chain_in(chain0), .chain_out(co0),
    .casc_io(casc0)
  );
  csig_top u_hi (
    .clk(clk), .rst(rst), .role(2'd1), .comp_en(comp_en), .src_sel(src_sel),
    .bus_data(bus_h), .bus_qual(bus_qual), .mem_data(16'h0), .mem_valid(mem_valid),
    .seed_load(seed_load), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(wdh),
    .cfg_rdata(rdh), .sig_out(sigh), .chain_in(col), .chain_out(coh),
    .casc_io(casc_c)
  );
  csig_top u_lo (
    .clk(clk), .rst(rst), .role(2'd3), .comp_en(comp_en), .src_sel(src_sel),
    .bus_data(bus_l), .bus_qual(bus_qual), .mem_data(16'h0), .mem_valid(mem_valid),
    .seed_load(seed_load), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(wdl),
    .cfg_rdata(rdl), .sig_out(sigl), .chain_in(1'b0), .chain_out(col),
    .casc_io(casc_c)
  );

  function automatic logic [15:0] nx(input logic [15:0] s, input logic lsb,
                                     input logic [15:0] d, input logic [15:0] m);
    return {s[14:0], lsb} ^ (d & ~m);
  endfunction
  function automatic logic par(input logic [15:0] s, input logic [15:0] t);
    return ^(s & t);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic wr3(input logic [1:0] a, input logic [15:0] v0, vh, vl);
    cfg_we = 1; cfg_addr = a; wd0 = v0; wdh = vh; wdl = vl;
    @(negedge clk);
    cfg_we = 0;
  endtask
  task automatic wr(input logic [1:0] a, input logic [15:0] v);
    wr3(a, v, v, v);
  endtask
  task automatic load();
    seed_load = 1;
    @(negedge clk);
    seed_load = 0;
  endtask
  task automatic rd(input logic [1:0] a, input string req, input logic [15:0] exp);
    cfg_addr = a;
    @(negedge clk);
    chk(req, {16'h0, rd0}, {16'h0, exp});
  endtask
  task automatic do_reset();
    comp_en = 0; bus_qual = 0; mem_valid = 0; seed_load = 0; cfg_we = 0;
    tb_drv = 0; role = 2'd0; src_sel = 0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  // solo run of n live-bus steps against the reference model
  task automatic run_solo(input int n, input logic [15:0] m, t, sd, input string req);
    logic [15:0] e;
    role = 2'd0; comp_en = 0;
    wr(2'd0, m); wr(2'd1, t); wr(2'd2, sd); load();
    e = sd;
    chk(req, {16'h0, sig0}, {16'h0, e});
    src_sel = 0; comp_en = 1; bus_qual = 1;
    for (int i = 0; i < n; i++) begin
      logic [15:0] d;
      d = 16'($urandom);
      bus0 = d;
      #1;
      chk("R5 pin feedback", {31'h0, casc0}, {31'h0, par(e, t)});
      e = nx(e, par(e, t), d, m);
      @(negedge clk);
      chk(req, {16'h0, sig0}, {16'h0, e});
    end
    comp_en = 0; bus_qual = 0;
  endtask

  task automatic t_reset();
    rst = 1;
    @(negedge clk);
    chk("R1 sig in reset", {16'h0, sig0}, 32'h0);
    do_reset();
    chk("R1 sig after reset", {16'h0, sig0}, 32'h0);
    rd(2'd0, "R1 mask", 16'h0);
    rd(2'd1, "R1 taps", 16'hD008);
    rd(2'd2, "R1 seed", 16'h0);
  endtask

  task automatic t_solo();
    for (int k = 0; k < 4; k++)
      run_solo(40, 16'h0, 16'($urandom), 16'($urandom), "R2 R5 solo step");
  endtask

  task automatic t_mask();
    run_solo(20, 16'hFFFF, 16'h0, 16'h0, "R4 all masked");
    chk("R4 stays zero", {16'h0, sig0}, 32'h0);
    run_solo(30, 16'h0F0F, 16'($urandom), 16'($urandom), "R4 partial mask");
    run_solo(30, 16'($urandom), 16'($urandom), 16'($urandom), "R4 random mask");
  endtask

  task automatic t_hold();
    logic [15:0] s;
    run_solo(3, 16'h0, 16'h1234, 16'hBEEF, "R3 prep");
    s = sig0;
    comp_en = 1; bus_qual = 0; bus0 = 16'hFFFF;
    repeat (3) @(negedge clk);
    chk("R3 no qualifier", {16'h0, sig0}, {16'h0, s});
    comp_en = 0; bus_qual = 1;
    repeat (3) @(negedge clk);
    chk("R3 not enabled", {16'h0, sig0}, {16'h0, s});
    bus_qual = 0;
  endtask

  task automatic t_src();
    logic [15:0] e, t;
    t = 16'h8421;
    comp_en = 0; role = 2'd0;
    wr(2'd0, 16'h0); wr(2'd1, t); wr(2'd2, 16'h5A5A); load();
    e = 16'h5A5A;
    src_sel = 1; comp_en = 1; mem_valid = 1; bus_qual = 1;
    for (int i = 0; i < 8; i++) begin
      mem0 = 16'($urandom); bus0 = 16'($urandom);
      e = nx(e, par(e, t), mem0, 16'h0);
      @(negedge clk);
      chk("R6 memory source", {16'h0, sig0}, {16'h0, e});
    end
    mem_valid = 0; bus_qual = 1; bus0 = 16'hFFFF;
    @(negedge clk);
    chk("R6 bus strobe ignored", {16'h0, sig0}, {16'h0, e});
    src_sel = 0; bus_qual = 0; mem_valid = 1; mem0 = 16'hFFFF;
    @(negedge clk);
    chk("R6 memory strobe ignored", {16'h0, sig0}, {16'h0, e});
    bus_qual = 1; bus0 = 16'h00F0;
    e = nx(e, par(e, t), 16'h00F0, 16'h0);
    @(negedge clk);
    chk("R6 bus source", {16'h0, sig0}, {16'h0, e});
    comp_en = 0; bus_qual = 0; mem_valid = 0;
  endtask

  task automatic t_seed();
    comp_en = 0; role = 2'd0;
    wr(2'd2, 16'hC3A5);
    comp_en = 1; bus_qual = 1; bus0 = 16'h0FF0; seed_load = 1;
    @(negedge clk);
    seed_load = 0; comp_en = 0; bus_qual = 0;
    chk("R7 load beats step", {16'h0, sig0}, 32'h0000C3A5);
  endtask

  task automatic t_lock();
    comp_en = 0;
    wr(2'd0, 16'h00AA); wr(2'd2, 16'h1111);
    comp_en = 1; bus_qual = 0;
    wr(2'd0, 16'hFFFF); wr(2'd2, 16'h2222);
    comp_en = 0;
    rd(2'd0, "R8 mask locked", 16'h00AA);
    rd(2'd2, "R8 seed locked", 16'h1111);
  endtask

  task automatic t_read();
    logic [15:0] s;
    comp_en = 0;
    wr(2'd1, 16'h6006);
    rd(2'd1, "R9 taps readback", 16'h6006);
    s = sig0;
    rd(2'd3, "R9 sig readback", s);
    repeat (2) @(negedge clk);
    chk("R9 read leaves sig", {16'h0, sig0}, {16'h0, s});
  endtask

  task automatic t_pin();
    logic [15:0] e, t;
    t = 16'hA001;
    comp_en = 0; role = 2'd3;
    wr(2'd0, 16'h0); wr(2'd1, t); wr(2'd2, 16'h8001); load();
    e = 16'h8001;
    src_sel = 0; bus0 = 16'h0; bus_qual = 1; comp_en = 1;
    tb_drv = 1; tb_val = 1;
    e = nx(e, 1'b1, 16'h0, 16'h0);
    @(negedge clk);
    chk("R10 R11 tail takes pin 1", {16'h0, sig0}, {16'h0, e});
    tb_val = 0;
    e = nx(e, 1'b0, 16'h0, 16'h0);
    @(negedge clk);
    chk("R10 R11 tail takes pin 0", {16'h0, sig0}, {16'h0, e});
    comp_en = 0; role = 2'd2; chain0 = 1; tb_val = 0;
    @(negedge clk);
    comp_en = 1;
    e = nx(e, 1'b1, 16'h0, 16'h0);
    @(negedge clk);
    chk("R11 middle takes chain_in", {16'h0, sig0}, {16'h0, e});
    chk("R11 chain_out is top bit", {31'h0, co0}, {31'h0, e[15]});
    comp_en = 0; tb_drv = 0; role = 2'd1; chain0 = 0;
    @(negedge clk);
    chk("R10 head drives feedback", {31'h0, casc0}, {31'h0, par(e, t)});
    comp_en = 1;
    e = nx(e, 1'b0, 16'h0, 16'h0);
    @(negedge clk);
    chk("R11 head takes chain_in", {16'h0, sig0}, {16'h0, e});
    comp_en = 0; bus_qual = 0; role = 2'd0;
  endtask

  task automatic t_cascade();
    logic [31:0] e, m;
    logic [15:0] th;
    for (int k = 0; k < 3; k++) begin
      comp_en = 0; role = 2'd0;
      th = 16'($urandom) | 16'h8000;
      m  = (k == 0) ? 32'h0 : $urandom;
      e  = $urandom;
      wr3(2'd0, 16'h0, m[31:16], m[15:0]);
      wr3(2'd1, 16'h0, th, 16'h0);
      wr3(2'd2, 16'h0, e[31:16], e[15:0]);
      load();
      src_sel = 0; comp_en = 1; bus_qual = 1;
      for (int i = 0; i < 50; i++) begin
        logic [31:0] d;
        logic f;
        d = $urandom;
        bus_h = d[31:16]; bus_l = d[15:0];
        f = ^(e[31:16] & th);
        e = {e[30:0], f} ^ (d & ~m);
        @(negedge clk);
        chk("R12 chained pair", {sigh, sigl}, e);
      end
      comp_en = 0; bus_qual = 0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_solo();
    t_mask();
    t_hold();
    t_src();
    t_seed();
    t_lock();
    t_read();
    t_pin();
    t_cascade();
    done = 1;
    summary();
  end
endmodule